// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block gathers five hardware interrupt sources for an 8-bit processor core and presents them one at a time. The sources are of three kinds. One non-maskable line is caught on a rising edge. One edge-latched restart line keeps a short pulse until it is serviced. Two level-sensed restart lines count only while they are held high. One general line supplies its own vector from outside. The four maskable sources are gated by a global enable that the core sets and clears with single-cycle pulses. The three restart lines are also gated by individual mask bits.

Among the sources that may request, a fixed priority picks one. The block raises a pending flag and shows that source's 16-bit restart address. When the core acknowledges, the block drives an active-low acknowledge strobe one cycle later. It clears the accepted source's latch and, for a maskable source, drops the global enable. A wake output lets a halted core resume when a request is pending, and it is also high during reset.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irq_pending is 0, ack_n is 1, the global enable is cleared, all three mask bits are set (blocked) and both edge latches are empty.
- R2: The non-maskable line requests regardless of the global enable and the mask bits, has the highest priority, and its vector is 0x0024.
- R3: The non-maskable line is caught on a rising edge and stays pending only while the line is still high. A line held high after acknowledge does not fire again, and a line that drops before acknowledge withdraws its request.
- R4: A rising edge on the edge-latched restart line is stored even for a one-cycle pulse, and even while the line is masked or the enable is clear. The stored edge requests with vector 0x003C once the line is enabled and unmasked.
- R5: The two level restart lines request only while held high, with vector 0x0034 for the upper one and 0x002C for the lower one.
- R6: The general line requests with the vector given on ext_vector.
- R7: Fixed priority is non-maskable, edge restart, upper level, lower level, general. irq_vector always shows the highest-priority requester.
- R8: en_pulse sets the global enable and dis_pulse clears it. Accepting any maskable request clears the enable, and accepting the non-maskable request leaves it unchanged.
- R9: mask_wr loads mask_wdata into the masks, where bit 2 is the edge restart line, bit 1 the upper level line and bit 0 the lower level line, and 1 blocks the line. mask_wr with mask_clr_edge also empties the edge latch.
- R10: ack high at a clock edge while irq_pending is high makes ack_n low in the next cycle and clears the accepted source's latch. ack while nothing is pending has no effect.
- R11: wake is high while reset is asserted and whenever irq_pending is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_req | input | 1 | Non-maskable request |
| edge_req | input | 1 | Edge-latched restart request |
| lvl_hi_req | input | 1 | Upper level-sensed restart request |
| lvl_lo_req | input | 1 | Lower level-sensed restart request |
| ext_req | input | 1 | General request |
| ext_vector | input | 16 | Vector for the general request |
| en_pulse | input | 1 | Set global enable |
| dis_pulse | input | 1 | Clear global enable |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 3 | New mask bits |
| mask_clr_edge | input | 1 | With mask_wr, empty the edge latch |
| ack | input | 1 | Core accepts the shown request |
| irq_pending | output | 1 | A request is ready |
| irq_vector | output | 16 | Restart address of the winner |
| ack_n | output | 1 | Acknowledge strobe, active low |
| wake | output | 1 | Resume a halted core |

## Verification
On every cycle the assertions check these properties. A non-maskable rising edge is pending with its vector one cycle later. A stored restart edge survives into the latch. ack_n only falls after an acknowledge of a pending request. Accepting a maskable request drops the enable. No maskable vector is shown while the enable is clear. wake follows pending. Only the bench scenarios can show the full priority order across all 32 request combinations, the mask write and latch clearing sequences, the one-shot behaviour of a held non-maskable line, and the exact vector values.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    localparam int NSRC  = 5;
    localparam int VEC_W = 16;
    localparam int NMASK = 3;

    typedef enum logic [2:0] {
        SRC_NMI  = 3'd0,
        SRC_EDGE = 3'd1,
        SRC_HI   = 3'd2,
        SRC_LO   = 3'd3,
        SRC_EXT  = 3'd4
    } src_e;

    localparam logic [VEC_W-1:0] VEC_NMI  = 16'h0024;
    localparam logic [VEC_W-1:0] VEC_EDGE = 16'h003C;
    localparam logic [VEC_W-1:0] VEC_HI   = 16'h0034;
    localparam logic [VEC_W-1:0] VEC_LO   = 16'h002C;
endpackage

// File: rtl/prio_irq_edge.sv
module prio_irq_edge #(
    parameter bit HOLD_HIGH = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic clr,
    output logic pend
);
    typedef struct packed {
        logic prev;
        logic lat;
    } st_t;

    st_t st_d, st_q;
    logic rise, keep;

    always_comb begin
        rise = din & ~st_q.prev;
        keep = st_q.lat & ~clr;
        if (HOLD_HIGH) keep = keep & din;
        st_d.prev = din;
        st_d.lat  = rise | keep;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.lat;
endmodule

// File: rtl/prio_irq_pick.sv
module prio_irq_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant[i]  = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end

    assign any = seen[N];
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_req,
    input  logic             edge_req,
    input  logic             lvl_hi_req,
    input  logic             lvl_lo_req,
    input  logic             ext_req,
    input  logic [VEC_W-1:0] ext_vector,
    input  logic             en_pulse,
    input  logic             dis_pulse,
    input  logic             mask_wr,
    input  logic [NMASK-1:0] mask_wdata,
    input  logic             mask_clr_edge,
    input  logic             ack,
    output logic             irq_pending,
    output logic [VEC_W-1:0] irq_vector,
    output logic             ack_n,
    output logic             wake
);
    localparam int MB_EDGE = 2;
    localparam int MB_HI   = 1;
    localparam int MB_LO   = 0;

    typedef struct packed {
        logic             ie;
        logic [NMASK-1:0] mask;
        logic             ackn;
    } st_t;

    st_t st_d, st_q;

    logic            nmi_pend, edge_pend;
    logic            nmi_clr, edge_clr;
    logic [NSRC-1:0] req, grant;
    logic            any, accept;
    logic            ie_flag;

    assign accept = ack & any;
    assign nmi_clr  = accept & grant[SRC_NMI];
    assign edge_clr = (accept & grant[SRC_EDGE]) | (mask_wr & mask_clr_edge);

    prio_irq_edge #(.HOLD_HIGH(1'b1)) u_nmi (
        .clk(clk), .rst_n(rst_n), .din(nmi_req), .clr(nmi_clr), .pend(nmi_pend)
    );

    prio_irq_edge #(.HOLD_HIGH(1'b0)) u_edge (
        .clk(clk), .rst_n(rst_n), .din(edge_req), .clr(edge_clr), .pend(edge_pend)
    );

    always_comb begin
        req           = '0;
        req[SRC_NMI]  = nmi_pend;
        req[SRC_EDGE] = st_q.ie & ~st_q.mask[MB_EDGE] & edge_pend;
        req[SRC_HI]   = st_q.ie & ~st_q.mask[MB_HI] & lvl_hi_req;
        req[SRC_LO]   = st_q.ie & ~st_q.mask[MB_LO] & lvl_lo_req;
        req[SRC_EXT]  = st_q.ie & ext_req;
    end

    prio_irq_pick #(.N(NSRC)) u_pick (
        .req(req), .grant(grant), .any(any)
    );

    always_comb begin
        irq_vector = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) begin
                case (src_e'(i))
                    SRC_NMI:  irq_vector = VEC_NMI;
                    SRC_EDGE: irq_vector = VEC_EDGE;
                    SRC_HI:   irq_vector = VEC_HI;
                    SRC_LO:   irq_vector = VEC_LO;
                    default:  irq_vector = ext_vector;
                endcase
            end
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.ackn = ~accept;
        if (accept && !grant[SRC_NMI]) st_d.ie = 1'b0;
        else if (dis_pulse)            st_d.ie = 1'b0;
        else if (en_pulse)             st_d.ie = 1'b1;
        if (mask_wr) st_d.mask = mask_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ie   <= 1'b0;
            st_q.mask <= '1;
            st_q.ackn <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ie_flag     = st_q.ie;
    assign irq_pending = any;
    assign ack_n       = st_q.ackn;
    assign wake        = ~rst_n | any;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
    import prio_irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             nmi_req,
    input logic             edge_req,
    input logic             ack,
    input logic             irq_pending,
    input logic [VEC_W-1:0] irq_vector,
    input logic             ack_n,
    input logic             wake,
    input logic             ie_flag,
    input logic             edge_pend,
    input logic             nmi_win
);
    p_nmi_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_req) |=> (irq_pending && irq_vector == VEC_NMI));

    p_edge_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(edge_req) |=> edge_pend);

    p_ackn_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> $past(ack && irq_pending));

    p_ie_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_pending && !nmi_win) |=> !ie_flag);

    p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending && !ie_flag) |-> irq_vector == VEC_NMI);

    p_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> wake);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .edge_req(edge_req),
    .ack(ack), .irq_pending(irq_pending), .irq_vector(irq_vector),
    .ack_n(ack_n), .wake(wake), .ie_flag(ie_flag), .edge_pend(edge_pend),
    .nmi_win(grant[0])
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_req = 0, edge_req = 0, lvl_hi_req = 0, lvl_lo_req = 0, ext_req = 0;
    logic [15:0] ext_vector = 16'h1230;
    logic        en_pulse = 0, dis_pulse = 0, mask_wr = 0, mask_clr_edge = 0, ack = 0;
    logic [2:0]  mask_wdata = 3'b000;
    logic        irq_pending, ack_n, wake;
    logic [15:0] irq_vector;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .edge_req(edge_req),
        .lvl_hi_req(lvl_hi_req), .lvl_lo_req(lvl_lo_req), .ext_req(ext_req),
        .ext_vector(ext_vector), .en_pulse(en_pulse), .dis_pulse(dis_pulse),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata), .mask_clr_edge(mask_clr_edge),
        .ack(ack), .irq_pending(irq_pending), .irq_vector(irq_vector),
        .ack_n(ack_n), .wake(wake)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic enable();
        en_pulse = 1; step(); en_pulse = 0;
    endtask

    task automatic wmask(input logic [2:0] m, input logic clr);
        mask_wr = 1; mask_wdata = m; mask_clr_edge = clr; step();
        mask_wr = 0; mask_clr_edge = 0;
    endtask

    task automatic do_ack();
        ack = 1; step(); ack = 0;
    endtask

    function automatic logic [15:0] exp_vec(input logic [4:0] m);
        if (m[0]) return 16'h0024;
        if (m[1]) return 16'h003C;
        if (m[2]) return 16'h0034;
        if (m[3]) return 16'h002C;
        return ext_vector;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        check("R11 wake in reset", wake, 1);
        step();
        rst_n = 1;
        step();
        // R1 reset state
        check("R1 pending", irq_pending, 0);
        check("R1 ack_n", ack_n, 1);
        check("R11 wake idle", wake, 0);
        // R1: masks set, ie clear -> levels ignored
        lvl_hi_req = 1; lvl_lo_req = 1; ext_req = 1; step();
        check("R1 ie clear", irq_pending, 0);
        enable();
        check("R1 masks set: ext only", irq_vector, 16'h1230);
        check("R6 ext pending", irq_pending, 1);
        lvl_hi_req = 0; lvl_lo_req = 0; ext_req = 0;
        dis_pulse = 1; step(); dis_pulse = 0;
        // R10 ack with nothing pending
        do_ack();
        check("R10 idle ack ignored", ack_n, 1);

        // R2/R3 nmi with ie clear and all masked
        nmi_req = 1; step();
        check("R2 nmi pending", irq_pending, 1);
        check("R2 nmi vector", irq_vector, 16'h0024);
        check("R11 wake follows", wake, 1);
        do_ack();
        check("R10 ack_n low", ack_n, 0);
        check("R3 nmi cleared", irq_pending, 0);
        step();
        check("R10 ack_n back", ack_n, 1);
        check("R3 held nmi no refire", irq_pending, 0);
        nmi_req = 0; step();
        nmi_req = 1; step();
        check("R3 new edge", irq_pending, 1);
        nmi_req = 0; step();
        check("R3 withdrawn", irq_pending, 0);

        // R4 edge latch, masked and disabled
        wmask(3'b100, 0);
        edge_req = 1; step(); edge_req = 0; step();
        check("R4 not while off", irq_pending, 0);
        enable();
        check("R9 masked edge", irq_pending, 0);
        wmask(3'b000, 0);
        check("R4 kept edge", irq_vector, 16'h003C);
        check("R4 kept pending", irq_pending, 1);
        do_ack();
        check("R8 ie dropped after accept", irq_pending, 0);
        enable();
        check("R10 edge latch cleared by ack", irq_pending, 0);
        // R9 mask clear of latch
        edge_req = 1; step(); edge_req = 0;
        check("R4 one-cycle pulse", irq_vector, 16'h003C);
        wmask(3'b000, 1);
        check("R9 latch cleared", irq_pending, 0);
        // R5 levels
        lvl_lo_req = 1; step();
        check("R5 low level", irq_vector, 16'h002C);
        lvl_hi_req = 1; step();
        check("R7 hi over lo", irq_vector, 16'h0034);
        lvl_hi_req = 0; step();
        check("R5 hi gone", irq_vector, 16'h002C);
        wmask(3'b001, 0);
        check("R9 lo masked", irq_pending, 0);
        lvl_lo_req = 0; wmask(3'b000, 0);
        // R8 nmi accept keeps ie
        lvl_hi_req = 1; nmi_req = 0; step();
        nmi_req = 1; step();
        check("R7 nmi over hi", irq_vector, 16'h0024);
        do_ack();
        check("R8 ie kept after nmi", irq_vector, 16'h0034);
        dis_pulse = 1; step(); dis_pulse = 0;
        check("R8 disable", irq_pending, 0);
        lvl_hi_req = 0; nmi_req = 0; step();

        // R7 sweep of all request combinations
        for (int m = 0; m < 32; m++) begin
            logic [4:0] b;
            b = m[4:0];
            nmi_req = b[0]; edge_req = b[1]; lvl_hi_req = b[2];
            lvl_lo_req = b[3]; ext_req = b[4];
            en_pulse = 1; mask_wr = 1; mask_wdata = 3'b000;
            step();
            en_pulse = 0; mask_wr = 0; edge_req = 0;
            check("R7 sweep pending", irq_pending, (b != 0));
            if (b != 0) check("R7 sweep vector", irq_vector, exp_vec(b));
            step();
            if (b != 0) check("R7 sweep hold", irq_vector, exp_vec(b));
            nmi_req = 0; lvl_hi_req = 0; lvl_lo_req = 0; ext_req = 0;
            dis_pulse = 1; mask_wr = 1; mask_clr_edge = 1;
            step();
            dis_pulse = 0; mask_wr = 0; mask_clr_edge = 0;
            step();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule